// File: doc/BRIEF.md
# Decision Tree Child Index Calculator

This stage walks one internal node of a multi-field cutting decision tree per clock. Each cycle it can take a five-field packet key and the full word of one internal node. The node word carries a control pair (a mask and a shift amount) for every field, and a table of child descriptors. The stage takes the top byte of each key field and ANDs it with that field's mask. It shifts the result left by that field's shift amount and adds the five terms to form a child index. It then looks up the descriptor at that index and outputs the child's kind (leaf or internal), its memory word address and its starting slot inside that word.

A tree-walk engine feeds the stage with the node word it has just read from memory and the key of the packet in flight. The registered outputs come back one cycle later and give the address of the next word to fetch. They also tell the engine whether that word holds another internal node or a leaf of rules. The stage does not build the tree, hold the node memory or match rules.

Top module: `dt_child_sel`

## Requirements
- R1: While `rst` is high, and after it until the first accepted node, `out_valid`, `out_is_leaf`, `out_addr`, `out_slot` and `out_index` are all zero.
- R2: `out_valid` is high in exactly the cycle after a clock edge at which `in_valid` was high, and low otherwise.
- R3: The key is packed as source address in bits 103:72, destination address 71:40, source port 39:24, destination port 23:8 and protocol 7:0. Field d (0 to 4, in that order) contributes its most significant byte, which sits at key bits 103:96, 71:64, 39:32, 23:16 and 7:0 respectively.
- R4: The control pair of field d sits above the descriptor table, at offset NUM_CHILD*18 + 16*d in the node word. Its mask takes the low byte and its shift amount the high byte. The mask is ANDed bitwise with that field's top byte, so an all-zero mask in every field selects child 0.
- R5: Each masked byte is shifted left by its shift amount and truncated to 8 bits. A shift amount of 8 or more makes that field's term zero.
- R6: The child index is the sum of the five terms modulo NUM_CHILD, which is the 8-bit truncated sum at the default NUM_CHILD of 256. It is presented on `out_index`.
- R7: Descriptor i occupies node bits i*18 to i*18+17. Its bits 4:0 are the slot, bits 16:5 the word address and bit 17 the kind, where 1 means leaf. The outputs carry exactly the fields of the descriptor at the computed index.
- R8: In a cycle where `in_valid` is low, the data outputs keep their previous values whatever `key_in` and `node_in` carry.
- R9: A new node and key can be accepted on every clock, and each result depends only on the inputs accepted at its own edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Key and node word are presented this cycle |
| key_in | input | 104 | Packed five-field packet key |
| node_in | input | NUM_CHILD*18+80 | Internal node word: descriptor table, then the five control pairs |
| out_valid | output | 1 | Result strobe, one cycle after acceptance |
| out_is_leaf | output | 1 | Selected child is a leaf (1) or internal node (0) |
| out_addr | output | 12 | Memory word address of the selected child |
| out_slot | output | 5 | Starting slot of the child in its word |
| out_index | output | 8 | Computed child index |

## Verification
The bench builds the stage with its default parameters: a 256-entry child table, 12-bit addresses and 5-bit slots. At that size the extreme entries 0 and 255 can be reached, and sums that exceed 255 wrap across the full 8-bit index. Because each descriptor is 18 bits wide, a misplaced descriptor boundary in the table shows up as corrupted fields. Shift amounts from 0 up to and past 8 are driven, together with single-field and mixed masks. Back-to-back nodes with changing tables are also applied, and so are idle cycles in which the inputs change.

// File: rtl/dt_pkg.sv
package dt_pkg;

    localparam int NUM_DIMS = 5;
    localparam int BYTE_W   = 8;
    localparam int KEY_W    = 104;
    localparam int CTL_W    = 16;
    localparam int HDR_W    = NUM_DIMS * CTL_W;
    localparam int SUM_W    = BYTE_W + $clog2(NUM_DIMS);

    typedef logic [BYTE_W-1:0] byte_t;

    // control pair for one field: shift amount above, mask below
    typedef struct packed {
        byte_t shamt;
        byte_t mask;
    } dim_ctl_t;

    // width of key field d, fields ordered from the key's top
    function automatic int dim_width(input int d);
        case (d)
            0, 1:    return 32;
            2, 3:    return 16;
            default: return 8;
        endcase
    endfunction

    // key bit position of the least significant bit of field d's top byte
    function automatic int top_byte_lsb(input int d);
        int pos;
        pos = 0;
        for (int k = NUM_DIMS - 1; k > d; k--) begin
            pos += dim_width(k);
        end
        return pos + dim_width(d) - BYTE_W;
    endfunction

    // left shift that vanishes once the amount reaches the byte width
    function automatic byte_t shl_term(input byte_t v, input byte_t amt);
        if (amt >= byte_t'(BYTE_W)) begin
            return '0;
        end
        return byte_t'(v << amt[2:0]);
    endfunction

endpackage

// File: rtl/dt_key_slicer.sv
module dt_key_slicer
    import dt_pkg::*;
(
    input  logic [KEY_W-1:0] key,
    output byte_t            top_bytes [NUM_DIMS]
);
    for (genvar d = 0; d < NUM_DIMS; d++) begin : g_dim
        localparam int LSB = top_byte_lsb(d);
        assign top_bytes[d] = key[LSB +: BYTE_W];
    end
endmodule

// File: rtl/dt_dim_term.sv
module dt_dim_term
    import dt_pkg::*;
(
    input  byte_t    field_byte,
    input  dim_ctl_t ctl,
    output byte_t    term
);
    byte_t masked;

    always_comb begin
        masked = field_byte & ctl.mask;
        term   = shl_term(masked, ctl.shamt);
    end
endmodule

// File: rtl/dt_desc_pick.sv
module dt_desc_pick #(
    parameter int NUM_CHILD = 256,
    parameter int DESC_W    = 18,
    localparam int IDX_W    = $clog2(NUM_CHILD),
    localparam int TBL_W    = NUM_CHILD * DESC_W
) (
    input  logic [TBL_W-1:0]  table_bits,
    input  logic [IDX_W-1:0]  idx,
    output logic [DESC_W-1:0] desc
);
    logic [DESC_W-1:0] entry [NUM_CHILD];

    for (genvar i = 0; i < NUM_CHILD; i++) begin : g_ent
        assign entry[i] = table_bits[i*DESC_W +: DESC_W];
    end

    assign desc = entry[idx];
endmodule

// File: rtl/dt_child_sel.sv
module dt_child_sel
    import dt_pkg::*;
#(
    parameter int NUM_CHILD = 256,
    parameter int ADDR_W    = 12,
    parameter int SLOT_W    = 5,
    localparam int IDX_W    = $clog2(NUM_CHILD),
    localparam int DESC_W   = 1 + ADDR_W + SLOT_W,
    localparam int TBL_W    = NUM_CHILD * DESC_W,
    localparam int NODE_W   = TBL_W + HDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [KEY_W-1:0]  key_in,
    input  logic [NODE_W-1:0] node_in,
    output logic              out_valid,
    output logic              out_is_leaf,
    output logic [ADDR_W-1:0] out_addr,
    output logic [SLOT_W-1:0] out_slot,
    output logic [IDX_W-1:0]  out_index
);
    byte_t             top_bytes [NUM_DIMS];
    byte_t             terms     [NUM_DIMS];
    dim_ctl_t          ctl       [NUM_DIMS];
    logic [SUM_W-1:0]  sum;
    logic [IDX_W-1:0]  idx;
    logic [DESC_W-1:0] desc;

    dt_key_slicer u_slicer (
        .key       (key_in),
        .top_bytes (top_bytes)
    );

    for (genvar d = 0; d < NUM_DIMS; d++) begin : g_term
        assign ctl[d] = dim_ctl_t'(node_in[TBL_W + d*CTL_W +: CTL_W]);
        dt_dim_term u_term (
            .field_byte (top_bytes[d]),
            .ctl        (ctl[d]),
            .term       (terms[d])
        );
    end

    always_comb begin
        sum = '0;
        for (int d = 0; d < NUM_DIMS; d++) begin
            sum = sum + SUM_W'(terms[d]);
        end
        idx = sum[IDX_W-1:0];
    end

    dt_desc_pick #(
        .NUM_CHILD (NUM_CHILD),
        .DESC_W    (DESC_W)
    ) u_pick (
        .table_bits (node_in[TBL_W-1:0]),
        .idx        (idx),
        .desc       (desc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_is_leaf <= 1'b0;
            out_addr    <= '0;
            out_slot    <= '0;
            out_index   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_is_leaf <= desc[DESC_W-1];
                out_addr    <= desc[SLOT_W +: ADDR_W];
                out_slot    <= desc[SLOT_W-1:0];
                out_index   <= idx;
            end
        end
    end
endmodule

// File: rtl/dt_child_sel_chk.sv
module dt_child_sel_chk
    import dt_pkg::*;
#(
    parameter int NUM_CHILD = 256,
    parameter int ADDR_W    = 12,
    parameter int SLOT_W    = 5,
    localparam int IDX_W    = $clog2(NUM_CHILD),
    localparam int DESC_W   = 1 + ADDR_W + SLOT_W,
    localparam int TBL_W    = NUM_CHILD * DESC_W,
    localparam int NODE_W   = TBL_W + HDR_W
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [NODE_W-1:0] node_in,
    input logic              out_valid,
    input logic              out_is_leaf,
    input logic [ADDR_W-1:0] out_addr,
    input logic [SLOT_W-1:0] out_slot,
    input logic [IDX_W-1:0]  out_index
);
    logic masks_zero;

    always_comb begin
        masks_zero = 1'b1;
        for (int d = 0; d < NUM_DIMS; d++) begin
            if (node_in[TBL_W + d*CTL_W +: BYTE_W] != '0) masks_zero = 1'b0;
        end
    end

    // R1
    always @(negedge clk) begin
        if (rst) begin
            reset_state_chk: assert (!out_valid && !out_is_leaf && out_addr == '0
                                     && out_slot == '0 && out_index == '0);
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |->
            ($stable(out_index) && $stable(out_addr) && $stable(out_slot) && $stable(out_is_leaf)));

    // R7
    desc_match_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid)) |->
            ({out_is_leaf, out_addr, out_slot} ==
             DESC_W'($past(node_in) >> (int'(out_index) * DESC_W))));

    // R4
    zero_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && $past(masks_zero)) |-> (out_index == '0));

endmodule

bind dt_child_sel dt_child_sel_chk #(
    .NUM_CHILD (NUM_CHILD),
    .ADDR_W    (ADDR_W),
    .SLOT_W    (SLOT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .node_in     (node_in),
    .out_valid   (out_valid),
    .out_is_leaf (out_is_leaf),
    .out_addr    (out_addr),
    .out_slot    (out_slot),
    .out_index   (out_index)
);

// File: tb/test_dt_child_sel.sv
module test_dt_child_sel;
    localparam int NC     = 256;
    localparam int AW     = 12;
    localparam int SW     = 5;
    localparam int DW     = 1 + AW + SW;
    localparam int NODE_W = NC * DW + 80;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [103:0]      key_in = '0;
    logic [NODE_W-1:0] node_in = '0;
    logic              out_valid;
    logic              out_is_leaf;
    logic [AW-1:0]     out_addr;
    logic [SW-1:0]     out_slot;
    logic [7:0]        out_index;

    always #5 clk = ~clk;

    dt_child_sel i_dt_child_sel (
        .clk(clk), .rst(rst), .in_valid(in_valid), .key_in(key_in), .node_in(node_in),
        .out_valid(out_valid), .out_is_leaf(out_is_leaf), .out_addr(out_addr),
        .out_slot(out_slot), .out_index(out_index)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;
    string cur_tag = "R1";

    // stimulus state
    int unsigned s_src, s_dst, s_sp, s_dp, s_pr;
    int b_mask [5];
    int b_shift[5];
    int d_leaf [NC];
    int d_addr [NC];
    int d_slot [NC];

    // model of the registered outputs
    int m_valid = 0, m_leaf = 0, m_addr = 0, m_slot = 0, m_idx = 0;

    function automatic int ref_index();
        int bytes[5];
        int sum;
        bytes[0] = int'((s_src >> 24) & 255);
        bytes[1] = int'((s_dst >> 24) & 255);
        bytes[2] = int'((s_sp >> 8) & 255);
        bytes[3] = int'((s_dp >> 8) & 255);
        bytes[4] = int'(s_pr & 255);
        sum = 0;
        for (int d = 0; d < 5; d++) begin
            int v;
            v = bytes[d] & b_mask[d];
            if (b_shift[d] < 8) sum += (v << b_shift[d]) & 255;
        end
        return sum % NC;
    endfunction

    task automatic fail_line(string tag, string what, int act, int exp);
        miscompares++;
        $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    endtask

    task automatic compare();
        vectors++;
        if (int'(out_valid) != m_valid) fail_line("R2", "out_valid", int'(out_valid), m_valid);
        if (int'(out_is_leaf) != m_leaf) fail_line(cur_tag, "out_is_leaf", int'(out_is_leaf), m_leaf);
        if (int'(out_addr) != m_addr) fail_line(cur_tag, "out_addr", int'(out_addr), m_addr);
        if (int'(out_slot) != m_slot) fail_line(cur_tag, "out_slot", int'(out_slot), m_slot);
        if (int'(out_index) != m_idx) fail_line(cur_tag, "out_index", int'(out_index), m_idx);
    endtask

    task automatic rand_desc();
        for (int i = 0; i < NC; i++) begin
            d_leaf[i] = int'($urandom % 2);
            d_addr[i] = int'($urandom % 4096);
            d_slot[i] = int'($urandom % 32);
        end
    endtask

    task automatic rand_key();
        s_src = $urandom; s_dst = $urandom;
        s_sp = $urandom % 65536; s_dp = $urandom % 65536; s_pr = $urandom % 256;
    endtask

    task automatic set_ctl(int d, int m, int s);
        b_mask[d] = m; b_shift[d] = s;
    endtask

    task automatic clear_ctl();
        for (int d = 0; d < 5; d++) set_ctl(d, 0, 0);
    endtask

    task automatic step(bit r, bit v);
        logic [NODE_W-1:0] n;
        int idx;
        @(negedge clk);
        compare();
        n = '0;
        for (int i = 0; i < NC; i++) begin
            n[i*DW +: DW] = {d_leaf[i][0], d_addr[i][AW-1:0], d_slot[i][SW-1:0]};
        end
        for (int d = 0; d < 5; d++) begin
            n[NC*DW + d*16 +: 8]     = b_mask[d][7:0];
            n[NC*DW + d*16 + 8 +: 8] = b_shift[d][7:0];
        end
        rst      = r;
        in_valid = v;
        key_in   = {s_src, s_dst, s_sp[15:0], s_dp[15:0], s_pr[7:0]};
        node_in  = n;
        if (r) begin
            m_valid = 0; m_leaf = 0; m_addr = 0; m_slot = 0; m_idx = 0;
        end else begin
            m_valid = int'(v);
            if (v) begin
                idx = ref_index();
                m_idx = idx; m_leaf = d_leaf[idx]; m_addr = d_addr[idx]; m_slot = d_slot[idx];
            end
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            miscompares++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        clear_ctl();
        rand_desc();
        rand_key();

        // R1: reset state, inputs busy during reset, then idle
        cur_tag = "R1";
        for (int i = 0; i < 3; i++) begin rand_key(); step(1, 1); end
        step(0, 0);
        step(0, 0);

        // R4: all masks zero pick child 0
        cur_tag = "R4";
        for (int i = 0; i < 4; i++) begin rand_key(); rand_desc(); step(0, 1); end

        // R3: each field alone, full mask, no shift, so index equals its top byte
        cur_tag = "R3";
        for (int d = 0; d < 5; d++) begin
            clear_ctl();
            set_ctl(d, 255, 0);
            for (int i = 0; i < 4; i++) begin rand_key(); step(0, 1); end
        end
        clear_ctl(); set_ctl(0, 255, 0);
        s_src = 32'hA5FF_FFFF; s_dst = 32'h5A00_0000; step(0, 1);

        // R4: partial masks over several fields
        cur_tag = "R4";
        clear_ctl();
        set_ctl(0, 8'h0F, 0); set_ctl(2, 8'h30, 0); set_ctl(4, 8'h80, 0);
        for (int i = 0; i < 8; i++) begin rand_key(); step(0, 1); end

        // R5: shift amounts 0 to 7, then 8 and beyond
        cur_tag = "R5";
        for (int s = 0; s < 12; s++) begin
            clear_ctl();
            set_ctl(1, 255, (s < 10) ? s : 200 + s);
            for (int i = 0; i < 2; i++) begin rand_key(); step(0, 1); end
        end
        clear_ctl(); set_ctl(3, 255, 8); set_ctl(4, 8'h01, 3);
        s_dp = 16'hFF00; s_pr = 8'h01; step(0, 1);

        // R6: sums of several terms, including wrap past 255
        cur_tag = "R6";
        for (int d = 0; d < 5; d++) set_ctl(d, 255, 0);
        s_src = 32'hFF00_0000; s_dst = 32'hFF00_0000; s_sp = 16'hFF00; s_dp = 16'h0200; s_pr = 8'h03;
        step(0, 1);
        for (int i = 0; i < 20; i++) begin
            for (int d = 0; d < 5; d++) set_ctl(d, int'($urandom % 256), int'($urandom % 8));
            rand_key(); step(0, 1);
        end

        // R7: extreme descriptor entries 0 and 255 with fresh tables
        cur_tag = "R7";
        clear_ctl(); set_ctl(4, 255, 0);
        for (int i = 0; i < 4; i++) begin
            rand_desc();
            d_leaf[0] = 1; d_addr[0] = 4095; d_slot[0] = 31;
            d_leaf[255] = 1; d_addr[255] = 4095; d_slot[255] = 31;
            d_leaf[1] = 0; d_addr[1] = 0; d_slot[1] = 0;
            d_leaf[254] = 0; d_addr[254] = 0; d_slot[254] = 0;
            s_pr = 0;   step(0, 1);
            s_pr = 255; step(0, 1);
            s_pr = 1;   step(0, 1);
            s_pr = 254; step(0, 1);
        end

        // R8: idle cycles with changing inputs leave the outputs untouched
        cur_tag = "R8";
        clear_ctl(); set_ctl(0, 255, 0);
        rand_key(); step(0, 1);
        for (int i = 0; i < 6; i++) begin
            rand_key(); rand_desc();
            for (int d = 0; d < 5; d++) set_ctl(d, int'($urandom % 256), int'($urandom % 8));
            step(0, 0);
        end

        // R9: one node per cycle with new tables, with occasional gaps
        cur_tag = "R9";
        for (int i = 0; i < 40; i++) begin
            rand_desc(); rand_key();
            for (int d = 0; d < 5; d++) set_ctl(d, int'($urandom % 256), int'($urandom % 9));
            step(0, (i % 7) != 3);
        end

        step(0, 0);
        step(0, 0);
        done = 1;
        summary();
        $finish;
    end
endmodule